// File: doc/BRIEF.md
# Shared Performance Counter Unit

This block counts hardware events for a whole socket. It has eight programmable counters and one fixed-function counter, each 48 bits wide. It is controlled through a plain register bus with a write strobe, an address, write data and combinational read data. Every clock, the unit takes a packed vector of small per-event increments. Each programmable counter picks one event code and adds the sub-events chosen by its unit mask. It can also turn that sum into a thresholded, inverted or edge-detected one-per-cycle count. The fixed counter adds one on every clock.

Software sets a period by preloading a counter with the two's complement of that period. The counter wraps to zero after exactly that many increments. The wrap sets a sticky flag in the status register. If the counter has its interrupt bit set, the overflow drives the interrupt line of each core selected by a routing field in the global control word. An optional freeze bit stops all counting while any overflow flag is pending.

A small controller tracks the unit's condition in three states:
- `ST_IDLE`: no counter is globally enabled.
- `ST_RUN`: counting is allowed.
- `ST_FROZEN`: freeze is set and an overflow flag is pending.

The controller moves between these states as follows:
- IDLE→RUN when a global enable bit is set.
- RUN→IDLE when all global enable bits are cleared.
- Any state→FROZEN when freeze is set and an overflow flag is pending.
- FROZEN→RUN (or FROZEN→IDLE) when the overflow flags are cleared or freeze is dropped.

Counters advance only in `ST_RUN`. The state is registered from the next-cycle control and status values, so freezing takes effect on the clock edge that records the overflow.

Top module: `socket_perf_unit`

## Requirements
- R1: After reset, every register and counter reads zero and every `irq_o` line is low.
- R2: Register addresses are:
  - global control 0x391, global status 0x392, overflow clear 0x393;
  - fixed counter 0x394, fixed control 0x395;
  - programmable counter n at 0x3B0+n, event select n at 0x3C0+n.

  Global control stores only these bits:
  - bits 7:0, general enables;
  - bit 32, fixed enable;
  - bits 51:48, routing to cores 0..3;
  - bit 63, freeze.

  Event select stores only these bits:
  - bits 7:0, event code;
  - bits 15:8, unit mask;
  - bit 18, edge;
  - bit 20, interrupt enable;
  - bit 22, local enable;
  - bit 23, invert;
  - bits 31:24, threshold.

  Fixed control stores bit 0 (enable) and bit 2 (interrupt enable). Every other bit reads zero. Counter writes keep the low 48 bits, and counter reads are zero-extended to 64 bits.
- R3: A programmable counter advances only when both its global and its local enable are set. With threshold zero, it adds per cycle the sum of the 4-bit increments of sub-events 0..3 of its event code whose unit-mask bits (bits 11:8) are set.
- R4: With a nonzero threshold, a counter adds 1 in each cycle where the sum is at least the threshold. When invert is set, it adds 1 in each cycle where the sum is below the threshold.
- R5: With edge set, a counter adds 1 only on a 0-to-1 change of its threshold condition (threshold 0 is treated as 1).
- R6: The fixed counter adds one per clock while global bit 32 and fixed control bit 0 are both set.
- R7: Counters wrap from 2^48-1 to zero. A wrap sets sticky status bit n (programmable counter n) or bit 32 (fixed counter), and also sets status bit 63.
- R8: A wrap on a counter with its interrupt enable set also sets status bit 61. `irq_o[k]` is high while routing bit 48+k is set and any pending overflow flag belongs to an interrupt-enabled counter.
- R9: Writing ones to the overflow-clear register clears the matching status bits. Writes to the status register itself are ignored.
- R10: While freeze is set and any overflow flag is pending, no counter advances. Counting resumes on the edge after the flags are cleared.
- R11: A bus write to a counter replaces its value in that cycle, and that cycle's increment is discarded.
- R12: Writing an event select with bit 17 set zeroes its counter. Bit 17 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Combinational read data for `bus_addr` |
| evt_inc | input | 256 | Per-cycle increments: 16 events × 4 sub-events × 4 bits, sub-event j of event e at bits [(e*4+j)*4 +: 4] |
| irq_o | output | 4 | Per-core overflow interrupt lines |

## Verification
The assertions check the following on every cycle:
- write precedence over increments and the holding of idle counters;
- the one-per-cycle limit of thresholded counting;
- stickiness of overflow flags without a clear;
- entry into and holding of the frozen state;
- that no interrupt line is raised without a pending overflow.

Only the bench's scenarios can show the exact arithmetic:
- unit-mask sums, threshold, invert and edge counts over a known window;
- wrap timing from a preloaded period;
- status bit patterns and the routing of interrupts to a chosen core;
- the counts seen after a freeze is released.

// File: rtl/perf_pkg.sv
package perf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } unit_state_t;

    localparam logic [11:0] A_GCTRL  = 12'h391;
    localparam logic [11:0] A_STATUS = 12'h392;
    localparam logic [11:0] A_CLR    = 12'h393;
    localparam logic [11:0] A_FXCNT  = 12'h394;
    localparam logic [11:0] A_FXCTL  = 12'h395;
    localparam logic [11:0] A_GPCNT  = 12'h3B0;
    localparam logic [11:0] A_EVSEL  = 12'h3C0;

    localparam int GC_FIX   = 32;
    localparam int GC_ROUTE = 48;
    localparam int GC_FRZ   = 63;
    localparam int SB_FIX   = 32;
    localparam int SB_PMI   = 61;
    localparam int SB_CHG   = 63;

    localparam int ES_OCC  = 17;
    localparam int ES_EDGE = 18;
    localparam int ES_PMI  = 20;
    localparam int ES_EN   = 22;
    localparam int ES_INV  = 23;

    typedef struct packed {
        logic [7:0] cmask;
        logic       inv;
        logic       en;
        logic       pmi;
        logic       edge_en;
        logic [7:0] umask;
        logic [7:0] code;
    } evsel_t;

endpackage

// File: rtl/perf_evt_qual.sv
module perf_evt_qual #(
    parameter int NUM_EVT = 16,
    parameter int SUB_N   = 4,
    parameter int INC_W   = 4,
    parameter int SUM_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_EVT*SUB_N*INC_W-1:0] evt_inc,
    input  logic [7:0]                     code,
    input  logic [SUB_N-1:0]               umask,
    input  logic [7:0]                     cmask,
    input  logic                           inv,
    input  logic                           edge_en,
    output logic [SUM_W-1:0]               inc
);
    localparam int CW = (SUM_W > 8) ? SUM_W : 8;

    logic [SUM_W-1:0] sum;
    logic [CW-1:0]    sum_x, thr_x;
    logic             thr_mode, cond, cond_q;

    always_comb begin
        sum = '0;
        if (int'(code) < NUM_EVT) begin
            for (int j = 0; j < SUB_N; j++) begin
                if (umask[j])
                    sum = sum + SUM_W'(evt_inc[(int'(code)*SUB_N + j)*INC_W +: INC_W]);
            end
        end
    end

    always_comb begin
        thr_mode = (cmask != 8'd0) || edge_en;
        sum_x    = CW'(sum);
        thr_x    = (cmask == 8'd0) ? CW'(1) : CW'(cmask);
        cond     = inv ? (sum_x < thr_x) : (sum_x >= thr_x);
        if (!thr_mode)
            inc = sum;
        else if (edge_en)
            inc = SUM_W'(cond && !cond_q);
        else
            inc = SUM_W'(cond);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    // R4
    thr_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmask != 8'd0) |-> (inc <= SUM_W'(1)));

endmodule

// File: rtl/perf_cnt48.sv
module perf_cnt48 #(
    parameter int CNT_W  = 48,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_val,
    input  logic              clr,
    input  logic              adv,
    input  logic [STEP_W-1:0] inc,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf
);
    logic [CNT_W:0] nxt;

    always_comb begin
        nxt = {1'b0, cnt} + {{(CNT_W+1-STEP_W){1'b0}}, inc};
        ovf = adv && !wr_en && !clr && nxt[CNT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_en) cnt <= wr_val;
        else if (clr)   cnt <= '0;
        else if (adv)   cnt <= nxt[CNT_W-1:0];
    end

    // R11
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == $past(wr_val)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr && !adv) |=> $stable(cnt));

endmodule

// File: rtl/perf_freeze_fsm.sv
module perf_freeze_fsm
    import perf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        any_en_d,
    input  logic        frz_req_d,
    output unit_state_t st_q,
    output logic        count_ok
);
    unit_state_t st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (frz_req_d)     st_d = ST_FROZEN;
                else if (any_en_d) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (frz_req_d)     st_d = ST_FROZEN;
                else if (!any_en_d) st_d = ST_IDLE;
            end
            ST_FROZEN: begin
                if (!frz_req_d)    st_d = any_en_d ? ST_RUN : ST_IDLE;
            end
            default:               st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        count_ok = (st_q == ST_RUN);
    end

endmodule

// File: rtl/socket_perf_unit.sv
module socket_perf_unit
    import perf_pkg::*;
#(
    parameter int NUM_GP    = 8,
    parameter int CNT_W     = 48,
    parameter int NUM_CORES = 4,
    parameter int NUM_EVT   = 16,
    parameter int SUB_N     = 4,
    parameter int INC_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic [11:0]                    bus_addr,
    input  logic [63:0]                    bus_wdata,
    output logic [63:0]                    bus_rdata,
    input  logic [NUM_EVT*SUB_N*INC_W-1:0] evt_inc,
    output logic [NUM_CORES-1:0]           irq_o
);
    localparam int SUM_W = INC_W + $clog2(SUB_N);

    // control and status state
    logic [NUM_GP-1:0]    gp_en_q, gp_en_d;
    logic                 fx_en_q, fx_en_d;
    logic [NUM_CORES-1:0] route_q, route_d;
    logic                 frz_q, frz_d;
    logic                 fx_on_q, fx_pmi_q;
    logic [NUM_GP-1:0]    ovf_q, ovf_d;
    logic                 fovf_q, fovf_d, pmi_st_q, pmi_st_d, chg_q, chg_d;
    evsel_t               evsel_q [NUM_GP];

    logic                 wr_gc, wr_clr, wr_fx, wr_fxc;
    logic [NUM_GP-1:0]    wr_gp, wr_es, clr_gp, adv_gp, gp_ovf, pmi_vec;
    logic [NUM_GP-1:0][CNT_W-1:0] gp_cnt;
    logic [CNT_W-1:0]     fx_cnt;
    logic                 fx_ovf, count_ok, irq_pend;
    unit_state_t          st_q;

    wire unused_wdata = ^bus_wdata;

    always_comb begin
        wr_gc  = bus_wr && (bus_addr == A_GCTRL);
        wr_clr = bus_wr && (bus_addr == A_CLR);
        wr_fx  = bus_wr && (bus_addr == A_FXCNT);
        wr_fxc = bus_wr && (bus_addr == A_FXCTL);
    end

    // programmable counter slices
    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        localparam logic [11:0] MY_CNT = A_GPCNT + 12'(g);
        localparam logic [11:0] MY_SEL = A_EVSEL + 12'(g);
        logic [SUM_W-1:0] step;

        assign wr_gp[g]   = bus_wr && (bus_addr == MY_CNT);
        assign wr_es[g]   = bus_wr && (bus_addr == MY_SEL);
        assign clr_gp[g]  = wr_es[g] && bus_wdata[ES_OCC];
        assign adv_gp[g]  = count_ok && gp_en_q[g] && evsel_q[g].en;
        assign pmi_vec[g] = evsel_q[g].pmi;

        perf_evt_qual #(.NUM_EVT(NUM_EVT), .SUB_N(SUB_N), .INC_W(INC_W), .SUM_W(SUM_W)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_inc (evt_inc),
            .code    (evsel_q[g].code),
            .umask   (evsel_q[g].umask[SUB_N-1:0]),
            .cmask   (evsel_q[g].cmask),
            .inv     (evsel_q[g].inv),
            .edge_en (evsel_q[g].edge_en),
            .inc     (step)
        );

        perf_cnt48 #(.CNT_W(CNT_W), .STEP_W(SUM_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_gp[g]),
            .wr_val (bus_wdata[CNT_W-1:0]),
            .clr    (clr_gp[g]),
            .adv    (adv_gp[g]),
            .inc    (step),
            .cnt    (gp_cnt[g]),
            .ovf    (gp_ovf[g])
        );
    end

    perf_cnt48 #(.CNT_W(CNT_W), .STEP_W(SUM_W)) u_fx_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_fx),
        .wr_val (bus_wdata[CNT_W-1:0]),
        .clr    (1'b0),
        .adv    (count_ok && fx_en_q && fx_on_q),
        .inc    (SUM_W'(1)),
        .cnt    (fx_cnt),
        .ovf    (fx_ovf)
    );

    // next control and status values
    always_comb begin
        gp_en_d = gp_en_q;
        fx_en_d = fx_en_q;
        route_d = route_q;
        frz_d   = frz_q;
        if (wr_gc) begin
            gp_en_d = bus_wdata[NUM_GP-1:0];
            fx_en_d = bus_wdata[GC_FIX];
            route_d = bus_wdata[GC_ROUTE +: NUM_CORES];
            frz_d   = bus_wdata[GC_FRZ];
        end
        ovf_d    = ovf_q;
        fovf_d   = fovf_q;
        pmi_st_d = pmi_st_q;
        chg_d    = chg_q;
        if (wr_clr) begin
            ovf_d    = ovf_q & ~bus_wdata[NUM_GP-1:0];
            fovf_d   = fovf_q & ~bus_wdata[SB_FIX];
            pmi_st_d = pmi_st_q & ~bus_wdata[SB_PMI];
            chg_d    = chg_q & ~bus_wdata[SB_CHG];
        end
        ovf_d    = ovf_d | gp_ovf;
        fovf_d   = fovf_d | fx_ovf;
        pmi_st_d = pmi_st_d | (|(gp_ovf & pmi_vec)) | (fx_ovf && fx_pmi_q);
        chg_d    = chg_d | (|gp_ovf) | fx_ovf;
    end

    perf_freeze_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_en_d  ((|gp_en_d) || fx_en_d),
        .frz_req_d (frz_d && ((|ovf_d) || fovf_d)),
        .st_q      (st_q),
        .count_ok  (count_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gp_en_q  <= '0;
            fx_en_q  <= 1'b0;
            route_q  <= '0;
            frz_q    <= 1'b0;
            fx_on_q  <= 1'b0;
            fx_pmi_q <= 1'b0;
            ovf_q    <= '0;
            fovf_q   <= 1'b0;
            pmi_st_q <= 1'b0;
            chg_q    <= 1'b0;
            for (int i = 0; i < NUM_GP; i++) evsel_q[i] <= '0;
        end else begin
            gp_en_q  <= gp_en_d;
            fx_en_q  <= fx_en_d;
            route_q  <= route_d;
            frz_q    <= frz_d;
            ovf_q    <= ovf_d;
            fovf_q   <= fovf_d;
            pmi_st_q <= pmi_st_d;
            chg_q    <= chg_d;
            if (wr_fxc) begin
                fx_on_q  <= bus_wdata[0];
                fx_pmi_q <= bus_wdata[2];
            end
            for (int i = 0; i < NUM_GP; i++) begin
                if (wr_es[i]) begin
                    evsel_q[i].code    <= bus_wdata[7:0];
                    evsel_q[i].umask   <= bus_wdata[15:8];
                    evsel_q[i].edge_en <= bus_wdata[ES_EDGE];
                    evsel_q[i].pmi     <= bus_wdata[ES_PMI];
                    evsel_q[i].en      <= bus_wdata[ES_EN];
                    evsel_q[i].inv     <= bus_wdata[ES_INV];
                    evsel_q[i].cmask   <= bus_wdata[31:24];
                end
            end
        end
    end

    // interrupt routing
    always_comb begin
        irq_pend = (|(ovf_q & pmi_vec)) || (fovf_q && fx_pmi_q);
        irq_o    = route_q & {NUM_CORES{irq_pend}};
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_GCTRL: begin
                bus_rdata[NUM_GP-1:0]            = gp_en_q;
                bus_rdata[GC_FIX]                = fx_en_q;
                bus_rdata[GC_ROUTE +: NUM_CORES] = route_q;
                bus_rdata[GC_FRZ]                = frz_q;
            end
            A_STATUS: begin
                bus_rdata[NUM_GP-1:0] = ovf_q;
                bus_rdata[SB_FIX]     = fovf_q;
                bus_rdata[SB_PMI]     = pmi_st_q;
                bus_rdata[SB_CHG]     = chg_q;
            end
            A_FXCNT: bus_rdata = 64'(fx_cnt);
            A_FXCTL: bus_rdata = {61'd0, fx_pmi_q, 1'b0, fx_on_q};
            default: ;
        endcase
        for (int i = 0; i < NUM_GP; i++) begin
            if (bus_addr == A_GPCNT + 12'(i))
                bus_rdata = 64'(gp_cnt[i]);
            if (bus_addr == A_EVSEL + 12'(i))
                bus_rdata = {32'd0, evsel_q[i].cmask, evsel_q[i].inv, evsel_q[i].en, 1'b0,
                             evsel_q[i].pmi, 1'b0, evsel_q[i].edge_en, 2'b00,
                             evsel_q[i].umask, evsel_q[i].code};
        end
    end

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clr |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // R10
    frz_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && ((|ovf_q) || fovf_q)) |-> (st_q == ST_FROZEN));

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FROZEN && !bus_wr) |=> ($stable(gp_cnt) && $stable(fx_cnt)));

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> ((|ovf_q) || fovf_q));

endmodule

// File: tb/socket_perf_unit_tb.sv
module socket_perf_unit_tb;

    localparam logic [11:0] GCTRL = 12'h391, STAT = 12'h392, CLR = 12'h393;
    localparam logic [11:0] FXCNT = 12'h394, FXCTL = 12'h395;
    localparam logic [11:0] GPC = 12'h3B0, EVS = 12'h3C0;
    localparam logic [63:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [63:0]  bus_wdata = '0;
    logic [63:0]  bus_rdata;
    logic [255:0] evt = '0;
    logic [3:0]   irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    socket_perf_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_inc   (evt),
        .irq_o     (irq_o)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata, e, t);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [63:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk); #1;
    endtask

    task automatic set_ev(input int code, input int sub, input logic [3:0] v);
        evt[(code*4 + sub)*4 +: 4] = v;
    endtask

    function automatic logic [63:0] es(input logic [7:0] code, input logic [7:0] um,
                                       input logic [7:0] cm, input bit inv,
                                       input bit edg, input bit pmi);
        return {32'd0, cm, inv, 1'b1, 1'b0, pmi, 1'b0, edg, 2'b00, um, code};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(GCTRL, 64'd0, "R1 gctrl");
        rd(STAT, 64'd0, "R1 status");
        rd(GPC, 64'd0, "R1 counter0");
        rd(FXCNT, 64'd0, "R1 fixed");
        @(negedge clk); check({60'd0, irq_o}, 64'd0, "R1 irq");

        // R2 stored fields and widths, R12 occupancy reset
        wr(GCTRL, ONES);
        rd(GCTRL, 64'h800F_0001_0000_00FF, "R2 gctrl mask");
        wr(GCTRL, 64'd0);
        wr(GPC, 64'hABCD_1234_5678_9ABC);
        rd(GPC, 64'h0000_1234_5678_9ABC, "R2 counter width");
        wr(EVS, ONES);
        rd(EVS, 64'h0000_0000_FFD4_FFFF, "R2 evsel mask");
        rd(GPC, 64'd0, "R12 occupancy reset");
        wr(FXCTL, ONES);
        rd(FXCTL, 64'd5, "R2 fixed ctrl");
        wr(FXCTL, 64'd0);

        // R3 R4: constant sum of 5 over four counting edges
        wr(EVS + 12'd0, es(8'd3, 8'h05, 8'd0, 0, 0, 0));
        wr(EVS + 12'd1, es(8'd3, 8'h05, 8'd4, 0, 0, 0));
        wr(EVS + 12'd2, es(8'd3, 8'h05, 8'd6, 1, 0, 0));
        wr(EVS + 12'd5, es(8'd3, 8'h05, 8'd6, 0, 0, 0));
        set_ev(3, 0, 4'd2); set_ev(3, 1, 4'd7); set_ev(3, 2, 4'd3);
        wr(GCTRL, 64'h27);
        repeat (2) @(posedge clk);
        wr(GCTRL, 64'd0);
        evt = '0;
        rd(GPC + 12'd0, 64'd20, "R3 unit-mask sum");
        rd(GPC + 12'd1, 64'd4, "R4 threshold");
        rd(GPC + 12'd2, 64'd4, "R4 invert");
        rd(GPC + 12'd5, 64'd0, "R4 threshold not met");

        // R5 edge detection
        wr(EVS + 12'd3, es(8'd9, 8'h01, 8'd1, 0, 1, 0));
        wr(EVS + 12'd4, es(8'd9, 8'h01, 8'd0, 0, 0, 0));
        wr(GCTRL, 64'h18);
        set_ev(9, 0, 4'd1);
        repeat (2) @(posedge clk); #1 set_ev(9, 0, 4'd0);
        repeat (1) @(posedge clk); #1 set_ev(9, 0, 4'd1);
        repeat (3) @(posedge clk); #1 set_ev(9, 0, 4'd0);
        repeat (1) @(posedge clk);
        wr(GCTRL, 64'd0);
        rd(GPC + 12'd3, 64'd2, "R5 edge count");
        rd(GPC + 12'd4, 64'd5, "R3 plain count");

        // R11 write precedence
        set_ev(3, 0, 4'd2); set_ev(3, 2, 4'd3);
        wr(GCTRL, 64'h1);
        wr(GPC, 64'd100);
        wr(GCTRL, 64'd0);
        evt = '0;
        rd(GPC, 64'd110, "R11 write over increment");

        // R7 R8 wrap with interrupt
        set_ev(3, 0, 4'd1);
        wr(EVS + 12'd6, es(8'd3, 8'h05, 8'd0, 0, 0, 1));
        wr(GPC + 12'd6, 64'h0000_FFFF_FFFF_FFFD);
        wr(GCTRL, 64'h40);
        repeat (1) @(posedge clk);
        wr(GCTRL, 64'd0);
        rd(GPC + 12'd6, 64'd0, "R7 wrap");
        rd(STAT, 64'hA000_0000_0000_0040, "R7 status");
        wr(GCTRL, 64'h0004_0000_0000_0000);
        @(negedge clk); check({60'd0, irq_o}, 64'h4, "R8 irq route");

        // R9 clear
        wr(CLR, 64'h40);
        rd(STAT, 64'hA000_0000_0000_0000, "R9 partial clear");
        @(negedge clk); check({60'd0, irq_o}, 64'd0, "R8 irq drop");
        wr(STAT, ONES);
        rd(STAT, 64'hA000_0000_0000_0000, "R9 status write ignored");
        wr(CLR, ONES);
        rd(STAT, 64'd0, "R9 full clear");

        // R8 no interrupt without enable
        wr(EVS + 12'd7, es(8'd3, 8'h05, 8'd0, 0, 0, 0));
        wr(GPC + 12'd7, 64'h0000_FFFF_FFFF_FFFD);
        wr(GCTRL, 64'h0004_0000_0000_0080);
        repeat (1) @(posedge clk);
        wr(GCTRL, 64'h0004_0000_0000_0000);
        rd(STAT, 64'h8000_0000_0000_0080, "R8 no pmi status");
        @(negedge clk); check({60'd0, irq_o}, 64'd0, "R8 no pmi irq");
        wr(CLR, ONES);
        wr(GCTRL, 64'd0);

        // R10 freeze
        wr(EVS + 12'd0, es(8'd3, 8'h05, 8'd0, 0, 0, 0));
        wr(GPC, 64'd0);
        wr(GPC + 12'd6, 64'h0000_FFFF_FFFF_FFFF);
        wr(GCTRL, 64'h8000_0000_0000_0041);
        repeat (4) @(posedge clk);
        rd(GPC, 64'd1, "R10 frozen counter0");
        rd(GPC + 12'd6, 64'd0, "R10 frozen counter6");
        rd(STAT, 64'hA000_0000_0000_0040, "R10 status while frozen");
        wr(CLR, ONES);
        wr(GCTRL, 64'd0);
        rd(GPC, 64'd3, "R10 resume counter0");
        rd(GPC + 12'd6, 64'd2, "R10 resume counter6");
        evt = '0;

        // R6 fixed counter
        wr(FXCTL, 64'h5);
        wr(FXCNT, 64'd10);
        wr(GCTRL, 64'h1_0000_0000);
        repeat (3) @(posedge clk);
        wr(GCTRL, 64'd0);
        rd(FXCNT, 64'd15, "R6 fixed per clock");
        wr(FXCNT, 64'h0000_FFFF_FFFF_FFFE);
        wr(GCTRL, 64'h1_0000_0000);
        wr(GCTRL, 64'd0);
        rd(FXCNT, 64'd0, "R6 fixed wrap");
        rd(STAT, 64'hA000_0001_0000_0000, "R7 fixed status");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule